// File: doc/BRIEF.md
# Programmable flag offset loader

This block sits beside a FIFO and fills two offset registers that the flag logic uses. The lower register sets how many words count as "almost empty". The upper register sets the "almost full" margin. Two select pins are read while reset is asserted. The value they hold at the last clock edge before reset is released picks one of four loading modes:

- two fixed preset values, each written into both registers,
- a parallel load that takes over the first two writes on the FIFO write port,
- a serial load that shifts one bit per write-clock edge through the select pins themselves.

Write readiness is held low until programming allows normal traffic. While the parallel load is in progress, qualified writes are diverted away from memory and a steal strobe marks each one. Once programming is complete, qualified writes are passed on as memory write enables. Offset values are meant to lie between 1 and 508 with the default 9-bit width. Keeping them in that range is up to whoever programs the block.

Top module: `flag_offset_loader`

## Requirements
- R1: The mode is the value of {sel_hi, sel_lo} at the last rising clock edge with rst high. 2'b00 is parallel load, 2'b01 is preset 8, 2'b10 is preset 64 and 2'b11 is serial load. After release, changes on the selects do not alter the mode.
- R2: While rst is high, and in the first cycle after release, in_ready, prog_done, mem_we and wr_steal are all 0, whatever wr_req is.
- R3: In a preset mode, empty_ofs and full_ofs both hold the preset value from the first cycle after release. in_ready and prog_done rise together after the second rising edge following release.
- R4: In parallel mode, in_ready rises after the second rising edge following release. The first qualified write (wr_req with in_ready high) loads full_ofs from wr_data[8:0], with bit 8 as the MSB. The second loads empty_ofs in the same way. Both writes show wr_steal=1 and mem_we=0.
- R5: In parallel mode, prog_done rises on the edge of the second qualified write. Later writes give mem_we=1 and wr_steal=0, and they leave both offsets unchanged.
- R6: In serial mode, each rising edge with sel_hi low shifts sel_lo into an 18-bit chain. The first bit ends up as the MSB of full_ofs and the 18th bit as the LSB of empty_ofs. Bits enter at the LSB of empty_ofs, so after 9 bits empty_ofs holds the first 9 bits. Edges with sel_hi high shift nothing.
- R7: In serial mode, in_ready stays low through the edge that loads the 18th bit. in_ready and prog_done both rise on the following edge. After that, further activity on the selects leaves both offsets unchanged.
- R8: mem_we is 1 exactly when wr_req, in_ready and prog_done are all 1. wr_req with in_ready low is ignored: no steal, no memory write and no change to either offset.
- R9: Once prog_done is high, prog_done, in_ready and both offsets hold until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset; the mode is captured while it is high |
| sel_hi | input | 1 | Mode select bit 1; serial enable (active low) after release in serial mode |
| sel_lo | input | 1 | Mode select bit 0; serial data after release in serial mode |
| wr_req | input | 1 | Already-qualified write request from the write port |
| wr_data | input | DATA_W | Write data; the low OFS_W bits feed the parallel load |
| empty_ofs | output | OFS_W | Almost-empty offset |
| full_ofs | output | OFS_W | Almost-full offset |
| in_ready | output | 1 | Write port may accept writes |
| prog_done | output | 1 | Offset programming finished |
| mem_we | output | 1 | Write forwarded to FIFO memory |
| wr_steal | output | 1 | Write consumed by the offset loader |

## Verification
The bench keeps the default parameters: a 9-bit offset width, a 36-bit data word, presets of 8 and 64, and a two-edge readiness delay. With these values the full 18-bit serial chain and the nine-bit parallel field can be exercised exhaustively in cycle terms. Random offsets in 1..508 are loaded both in parallel and serially. Random idle gaps, noise on the select pins and random upper data bits are mixed in. These show that only the intended edges and bits reach the registers.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

  // Encoding equals {sel_hi, sel_lo} sampled while reset is asserted.
  typedef enum logic [1:0] {
    LD_PARALLEL     = 2'b00,
    LD_PRESET_SMALL = 2'b01,
    LD_PRESET_LARGE = 2'b10,
    LD_SERIAL       = 2'b11
  } load_mode_e;

endpackage

// File: rtl/flag_mode_latch.sv
module flag_mode_latch
  import flag_ofs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_hi,
  input  logic       sel_lo,
  output load_mode_e mode
);

  // Tracks the selects during reset; frozen from the first cycle after release.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= load_mode_e'({sel_hi, sel_lo});
    end
  end

endmodule

// File: rtl/flag_ready_timer.sv
module flag_ready_timer #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  output logic elapsed
);

  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;

  // Counts rising edges after release and saturates at DELAY.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt != CW'(DELAY)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign elapsed = (cnt == CW'(DELAY));

endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs
  import flag_ofs_pkg::*;
#(
  parameter int OFS_W        = 9,
  parameter int PRESET_SMALL = 8,
  parameter int PRESET_LARGE = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_hi,
  input  logic             sel_lo,
  input  load_mode_e       mode,
  input  logic             par_we,
  input  logic [OFS_W-1:0] par_data,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic             par_done,
  output logic             ser_done
);

  localparam int SER_BITS = 2 * OFS_W;
  localparam int BCW      = $clog2(SER_BITS + 1);

  logic [BCW-1:0] bit_cnt;
  logic           full_loaded;
  logic           ser_shift;
  logic [OFS_W-1:0] preset_val;

  // Preset chosen from the live selects; the last reset cycle's value sticks.
  always_comb begin
    unique case ({sel_hi, sel_lo})
      2'b01:   preset_val = OFS_W'(PRESET_SMALL);
      2'b10:   preset_val = OFS_W'(PRESET_LARGE);
      default: preset_val = '0;
    endcase
  end

  assign ser_shift = (mode == LD_SERIAL) && !sel_hi && (bit_cnt != BCW'(SER_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_ofs   <= preset_val;
      full_ofs    <= preset_val;
      bit_cnt     <= '0;
      full_loaded <= 1'b0;
      par_done    <= 1'b0;
      ser_done    <= 1'b0;
    end else begin
      // Parallel load: upper offset first, lower offset second.
      if (par_we) begin
        if (!full_loaded) begin
          full_ofs    <= par_data;
          full_loaded <= 1'b1;
        end else begin
          empty_ofs <= par_data;
          par_done  <= 1'b1;
        end
      end
      // Serial load: one chain, new bits enter at the low end of empty_ofs.
      if (ser_shift) begin
        {full_ofs, empty_ofs} <= {full_ofs[OFS_W-2:0], empty_ofs, sel_lo};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if ((mode == LD_SERIAL) && (bit_cnt == BCW'(SER_BITS))) begin
        ser_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import flag_ofs_pkg::*;
#(
  parameter int DATA_W       = 36,
  parameter int OFS_W        = 9,
  parameter int PRESET_SMALL = 8,
  parameter int PRESET_LARGE = 64,
  parameter int READY_DELAY  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_hi,
  input  logic              sel_lo,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              in_ready,
  output logic              prog_done,
  output logic              mem_we,
  output logic              wr_steal
);

  load_mode_e mode;
  logic       elapsed;
  logic       par_done;
  logic       ser_done;
  logic       accept;
  logic       par_we;
  logic       unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:OFS_W];

  flag_mode_latch u_mode (
    .clk    (clk),
    .rst    (rst),
    .sel_hi (sel_hi),
    .sel_lo (sel_lo),
    .mode   (mode)
  );

  flag_ready_timer #(.DELAY(READY_DELAY)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .elapsed (elapsed)
  );

  flag_offset_regs #(
    .OFS_W        (OFS_W),
    .PRESET_SMALL (PRESET_SMALL),
    .PRESET_LARGE (PRESET_LARGE)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sel_hi    (sel_hi),
    .sel_lo    (sel_lo),
    .mode      (mode),
    .par_we    (par_we),
    .par_data  (wr_data[OFS_W-1:0]),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .par_done  (par_done),
    .ser_done  (ser_done)
  );

  // Readiness and completion are selected from registered sources.
  always_comb begin
    unique case (mode)
      LD_SERIAL: begin
        in_ready  = ser_done;
        prog_done = ser_done;
      end
      LD_PARALLEL: begin
        in_ready  = elapsed;
        prog_done = par_done;
      end
      default: begin
        in_ready  = elapsed;
        prog_done = elapsed;
      end
    endcase
  end

  assign accept   = wr_req & in_ready;
  assign mem_we   = accept & prog_done;
  assign wr_steal = accept & ~prog_done;
  assign par_we   = wr_steal & (mode == LD_PARALLEL);

endmodule

// File: rtl/flag_offset_loader_chk.sv
module flag_offset_loader_chk #(
  parameter int OFS_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_req,
  input logic [OFS_W-1:0] empty_ofs,
  input logic [OFS_W-1:0] full_ofs,
  input logic             in_ready,
  input logic             prog_done,
  input logic             mem_we,
  input logic             wr_steal
);

  assert_quiet_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!in_ready && !prog_done && !mem_we && !wr_steal));

  assert_steal_only_programming_R4: assert property (@(posedge clk) disable iff (rst)
    wr_steal |-> (wr_req && in_ready && !prog_done && !mem_we));

  assert_store_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (wr_req && in_ready && prog_done));

  assert_not_ready_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (!mem_we && !wr_steal));

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> (prog_done && in_ready && $stable(empty_ofs) && $stable(full_ofs)));

  assert_ready_holds_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

endmodule

bind flag_offset_loader flag_offset_loader_chk #(.OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_req    (wr_req),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .in_ready  (in_ready),
  .prog_done (prog_done),
  .mem_we    (mem_we),
  .wr_steal  (wr_steal)
);

// File: tb/tb_flag_offset_loader.sv
module tb_flag_offset_loader;

  localparam int DATA_W = 36;
  localparam int OFS_W  = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sel_hi = 1'b0;
  logic              sel_lo = 1'b0;
  logic              wr_req = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [OFS_W-1:0]  empty_ofs, full_ofs;
  logic              in_ready, prog_done, mem_we, wr_steal;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  flag_offset_loader dut (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .wr_req(wr_req), .wr_data(wr_data),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .in_ready(in_ready), .prog_done(prog_done),
    .mem_we(mem_we), .wr_steal(wr_steal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [OFS_W-1:0] preset_of(input logic hi);
    return hi ? OFS_W'(64) : OFS_W'(8);
  endfunction

  function automatic logic [OFS_W-1:0] rand_ofs();
    return OFS_W'($urandom_range(508, 1));
  endfunction

  // Reset with the given selects; returns at the negedge where rst drops.
  task automatic reset_into(input logic hi, input logic lo);
    @(negedge clk);
    rst = 1'b1; sel_hi = hi; sel_lo = lo; wr_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 reset in_ready", 32'(in_ready), 0);
    chk("R2 reset mem_we", 32'(mem_we), 0);
    rst = 1'b0; wr_req = 1'b0;
  endtask

  task automatic run_preset(input logic hi);
    reset_into(hi, ~hi);
    sel_hi = $urandom_range(1, 0); sel_lo = $urandom_range(1, 0);
    chk("R3 preset empty_ofs", 32'(empty_ofs), 32'(preset_of(hi)));
    chk("R3 preset full_ofs", 32'(full_ofs), 32'(preset_of(hi)));
    wr_req = 1'b1;
    #1 chk("R2 first cycle mem_we", 32'(mem_we), 0);
    @(negedge clk);
    chk("R3 in_ready after one edge", 32'(in_ready), 0);
    @(negedge clk);
    chk("R3 in_ready after two edges", 32'(in_ready), 1);
    chk("R3 prog_done after two edges", 32'(prog_done), 1);
    chk("R1 mode kept despite select noise", 32'(empty_ofs), 32'(preset_of(hi)));
    chk("R8 preset write stored", 32'(mem_we), 1);
    chk("R8 preset no steal", 32'(wr_steal), 0);
    wr_req = 1'b0;
  endtask

  task automatic run_parallel(input logic [OFS_W-1:0] yv, input logic [OFS_W-1:0] xv,
                              input int gap);
    reset_into(1'b0, 1'b0);
    wr_req = 1'b1; wr_data = {$urandom, $urandom};
    #1 chk("R8 write before ready no steal", 32'(wr_steal), 0);
    @(negedge clk);
    chk("R4 in_ready after one edge", 32'(in_ready), 0);
    @(negedge clk);
    chk("R8 ignored write left full_ofs", 32'(full_ofs), 0);
    chk("R4 in_ready after two edges", 32'(in_ready), 1);
    chk("R5 not done yet", 32'(prog_done), 0);
    wr_req = 1'b0;
    repeat (gap) @(negedge clk);
    wr_req = 1'b1;
    wr_data = {27'($urandom), yv};
    #1 chk("R4 first write stolen", 32'(wr_steal), 1);
    chk("R4 first write not stored", 32'(mem_we), 0);
    @(negedge clk);
    chk("R4 full_ofs loaded", 32'(full_ofs), 32'(yv));
    chk("R5 done after one write", 32'(prog_done), 0);
    wr_data = {27'($urandom), xv};
    #1 chk("R4 second write stolen", 32'(wr_steal), 1);
    @(negedge clk);
    chk("R4 empty_ofs loaded", 32'(empty_ofs), 32'(xv));
    chk("R5 done after two writes", 32'(prog_done), 1);
    wr_data = {$urandom, $urandom};
    #1 chk("R5 third write stored", 32'(mem_we), 1);
    chk("R5 third write no steal", 32'(wr_steal), 0);
    @(negedge clk);
    chk("R5 full_ofs unchanged", 32'(full_ofs), 32'(yv));
    chk("R9 empty_ofs held", 32'(empty_ofs), 32'(xv));
    wr_req = 1'b0;
  endtask

  task automatic run_serial(input logic [OFS_W-1:0] yv, input logic [OFS_W-1:0] xv,
                            input bit gaps);
    logic [2*OFS_W-1:0] chain;
    chain = {yv, xv};
    reset_into(1'b1, 1'b1);
    for (int i = 0; i < 2 * OFS_W; i++) begin
      if (gaps && ($urandom_range(3, 0) == 0)) begin
        sel_hi = 1'b1; sel_lo = $urandom_range(1, 0);
        @(negedge clk);
      end
      sel_hi = 1'b0; sel_lo = chain[2*OFS_W-1-i];
      wr_req = $urandom_range(1, 0);
      #1 chk("R8 serial write ignored", 32'(mem_we | wr_steal), 0);
      @(negedge clk);
      if (i == OFS_W - 1) chk("R6 half chain in empty_ofs", 32'(empty_ofs), 32'(yv));
    end
    chk("R7 not ready on last bit", 32'(in_ready), 0);
    sel_hi = 1'b0; sel_lo = ~sel_lo;
    @(negedge clk);
    chk("R7 ready after last bit", 32'(in_ready), 1);
    chk("R7 done after last bit", 32'(prog_done), 1);
    chk("R6 full_ofs serial", 32'(full_ofs), 32'(yv));
    chk("R6 empty_ofs serial", 32'(empty_ofs), 32'(xv));
    repeat (3) begin
      sel_hi = 1'b0; sel_lo = $urandom_range(1, 0);
      @(negedge clk);
    end
    chk("R7 full_ofs frozen", 32'(full_ofs), 32'(yv));
    chk("R7 empty_ofs frozen", 32'(empty_ofs), 32'(xv));
    sel_hi = 1'b0; wr_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_preset(1'b0);
    run_preset(1'b1);
    run_parallel(OFS_W'(1), OFS_W'(508), 0);
    run_parallel(OFS_W'(508), OFS_W'(1), 2);
    run_serial(OFS_W'(508), OFS_W'(1), 1'b0);
    run_serial(OFS_W'(1), OFS_W'(508), 1'b1);
    for (int k = 0; k < 20; k++) begin
      run_parallel(rand_ofs(), rand_ofs(), int'($urandom_range(3, 0)));
      run_serial(rand_ofs(), rand_ofs(), 1'b1);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule